// File: doc/BRIEF.md
# Strobed Sample Agreement Detector

This block watches a strobe input and a data input, both sampled on the system clock. Each time the strobe goes from low to high, the block stores the data value present at that clock. It keeps the value from the previous rising edge for comparison. While the strobe stays high, the output reports whether the value just stored equals the value stored at the rising edge before it. When the strobe goes low, the output drops.

The stored reference is kept through strobe-low periods of any length. Data changes after the capturing clock have no effect until the next rising edge. After reset there is no reference yet, so the first strobe pulse never raises the output. This makes the block a simple consistency monitor: it confirms that a qualifier line held the same level on two consecutive strobes. The data width is a parameter, and the comparison covers every bit.

Top module: `strobe_pair_match`

## Requirements
- R1: While `rst` is high at a rising clock edge, the block clears its reference-valid flag, its registered strobe and its agreement flag. `match` reads 0 after that edge.
- R2: A rising strobe edge is a clock edge at which `strobe` is 1 and `strobe` was 0 at the previous clock, or at which `strobe` is 1 at the first clock after reset. `match` is 0 after every clock edge at which `strobe` was sampled 0.
- R3: The first rising strobe edge after reset stores `sample` and leaves `match` at 0 for the whole high period that follows.
- R4: `match` goes to 1 after a rising strobe edge at which `sample` equals the value stored at the previous rising edge. It stays 1 until the first clock edge at which `strobe` is sampled 0.
- R5: At a rising strobe edge where `sample` differs from the stored value, `match` stays 0 for that high period, and the new `sample` becomes the reference for the next edge.
- R6: Changes of `sample` while the strobe stays high do not change `match` and do not change the stored reference.
- R7: The stored reference is kept across a strobe-low period of any length.
- R8: The comparison covers all DATA_W bits, so a difference in any single bit gives a mismatch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| strobe | input | 1 | Strobe; its rising edges capture `sample` |
| sample | input | DATA_W | Data value captured at each strobe rising edge |
| match | output | 1 | 1 while the strobe is high and the last two captures were equal |

## Verification
The bench builds the block with DATA_W = 3, so that a mismatch can be placed in each bit position and the check covers every bit of the comparison rather than a single line. Random data is drawn from a small set of values, so both equal and unequal consecutive captures occur often. Strobe pulses and low gaps of random length are mixed in, and also single-cycle pulses and long gaps, to exercise how the reference is held.

// File: rtl/strobe_pair_match.sv
module strobe_pair_match #(
  parameter int DATA_W = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strobe,
  input  logic [DATA_W-1:0] sample,
  output logic              match
);

  logic              strobe_q;
  logic              have_ref;
  logic              agree;
  logic [DATA_W-1:0] ref_q;
  logic              rise;

  assign rise  = strobe & ~strobe_q;
  assign match = strobe_q & agree;

  always_ff @(posedge clk) begin
    if (rst) begin
      strobe_q <= 1'b0;
      have_ref <= 1'b0;
      agree    <= 1'b0;
      ref_q    <= '0;
    end else begin
      strobe_q <= strobe;
      if (rise) begin
        ref_q    <= sample;
        have_ref <= 1'b1;
        agree    <= have_ref && (sample == ref_q);
      end
    end
  end

  AST_LOW_GATE: assert property (@(posedge clk) disable iff (rst)
    !strobe |=> !match);  // R2
  AST_FIRST_EDGE: assert property (@(posedge clk) disable iff (rst)
    (rise && !have_ref) |=> !match);  // R3
  AST_EQUAL_EDGE: assert property (@(posedge clk) disable iff (rst)
    (rise && have_ref && sample == ref_q) |=> match);  // R4
  AST_DIFF_EDGE: assert property (@(posedge clk) disable iff (rst)
    (rise && have_ref && sample != ref_q) |=> (!match && ref_q == $past(sample)));  // R5
  AST_HIGH_HOLD: assert property (@(posedge clk) disable iff (rst)
    (strobe_q && strobe) |=> ($stable(match) && $stable(ref_q)));  // R6
  AST_LOW_HOLD: assert property (@(posedge clk) disable iff (rst)
    !strobe |=> $stable(ref_q));  // R7

endmodule

// File: tb/test_strobe_pair_match.sv
module test_strobe_pair_match;
  localparam int W = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic strobe = 1'b0;
  logic [W-1:0] sample = '0;
  logic match;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  // reference model state, per the requirements
  bit m_sq, m_have, m_agree;
  logic [W-1:0] m_ref;

  always #2.5 clk = ~clk;

  strobe_pair_match #(.DATA_W(W)) i_strobe_pair_match (
    .clk(clk), .rst(rst), .strobe(strobe), .sample(sample), .match(match)
  );

  function automatic bit exp_match();
    return m_sq & m_agree;
  endfunction

  function automatic string auto_tag();
    if (!m_sq) return "R2";
    if (!m_agree) return "R5/R3";
    return "R4";
  endfunction

  task automatic check(input string tag, input logic got, input logic exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s: match=%0b expected %0b at %0t", tag, got, exp, $time);
    end
  endtask

  // apply inputs for one clock, then check at the following falling edge
  task automatic step(input logic s, input logic [W-1:0] d, input string tag);
    strobe = s;
    sample = d;
    if (rst) begin
      m_sq = 0; m_have = 0; m_agree = 0; m_ref = '0;
    end else begin
      if (s && !m_sq) begin
        m_agree = m_have && (d == m_ref);
        m_ref = d;
        m_have = 1;
      end
      m_sq = s;
    end
    @(negedge clk);
    check(tag == "" ? auto_tag() : tag, match, exp_match());
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: timeout, got hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    process_start();
  end

  task automatic process_start();
    logic [W-1:0] v;
    void'($urandom(32'h5EED));
    @(negedge clk);
    step(1'b1, 3'd5, "R1");
    step(1'b1, 3'd5, "R1");
    rst = 1'b0;
    step(1'b0, 3'd0, "R1");

    // R3: first pulse never raises match
    step(1'b1, 3'd2, "R3");
    step(1'b1, 3'd6, "R3");
    step(1'b0, 3'd6, "R2");
    // R4: equal second edge
    step(1'b1, 3'd2, "R4");
    step(1'b1, 3'd7, "R6");
    step(1'b1, 3'd0, "R6");
    step(1'b0, 3'd0, "R2");
    // R5: differing edge, new reference
    step(1'b1, 3'd3, "R5");
    step(1'b0, 3'd3, "R2");
    step(1'b1, 3'd3, "R5");
    step(1'b0, 3'd1, "R2");
    // R7: long low gap keeps reference 3
    for (int i = 0; i < 50; i++) step(1'b0, W'($urandom), "R7");
    step(1'b1, 3'd3, "R7");
    step(1'b0, 3'd3, "R2");
    // R8: one-bit difference in each lane
    for (int b = 0; b < W; b++) begin
      v = 3'd3 ^ W'(1 << b);
      step(1'b1, 3'd3, "R8");
      step(1'b0, 3'd0, "R2");
      step(1'b1, v, "R8");
      step(1'b0, 3'd0, "R2");
      step(1'b1, 3'd3, "R8");
      step(1'b0, 3'd0, "R2");
    end
    // single-cycle pulses
    step(1'b1, 3'd4, "");
    step(1'b0, 3'd4, "R2");
    step(1'b1, 3'd4, "R4");
    step(1'b0, 3'd4, "R2");

    // random phase
    for (int n = 0; n < 400; n++) begin
      logic [W-1:0] d;
      int hi, lo;
      d = ($urandom % 2) ? 3'd1 : 3'd6;
      hi = 1 + ($urandom % 4);
      lo = 1 + ($urandom % 4);
      step(1'b1, d, "");
      for (int k = 1; k < hi; k++) step(1'b1, W'($urandom), "R6");
      for (int k = 0; k < lo; k++) step(1'b0, W'($urandom), "R2");
      if (n == 200) begin
        rst = 1'b1;
        step(1'b0, 3'd0, "R1");
        rst = 1'b0;
        step(1'b1, d, "R3");
        step(1'b0, d, "R2");
      end
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask
endmodule